// File: doc/BRIEF.md
# SD Host Slot Wrapper Register Shell

This block sits between a 4 KiB, 32-bit memory-mapped register bus and one or two SD host slot controllers. The first 256 bytes of the window hold a small set of global registers: a slot-information word with a soft-reset request bit, a debounce setting, a bus setting, a write-protect polarity word, a card-detect word and an interrupt status word. The same page also holds writable shadow copies of each slot's 64-bit capability word and 32-bit maximum-current word. Each configured slot owns a 256-byte sub-window that the block passes to that slot's own register port.

Each slot's interrupt level is mirrored into the interrupt status word, and the block drives one combined interrupt output. Every access receives exactly one response strobe. A global access is answered one cycle after it is issued. A slot access is answered one cycle after the slot port answers. An access that hits no mapped word returns zero and raises an error strobe. The host keeps at most one slot access outstanding.

Top module: `sdw_wrap`

## Requirements
- R1: After reset the global reads return these values. The info word at 0x000 has bit 16+i set for every configured slot i and all other bits clear. The debounce word at 0x004 is 5. Each capability word equals the parameter CAP_INIT. Every other global word is 0. rsp_valid, irq_o and soft_rst_o are low.
- R2: A global access sets rsp_valid exactly one cycle after its request. The words at 0x004, 0x008, 0x0EC and 0x0F0 read back the last value written to them. A global write responds with data 0.
- R3: Bit 0 of the info word always reads back 0. Bits 31:1 read back as written.
- R4: A write to 0x000 with bit 0 set drives soft_rst_o high for one cycle, in the cycle after the request. A write there with bit 0 clear gives no pulse.
- R5: For slot i, the low half of the capability word is at 0x10*(i+1), the high half is at that offset +4, and the maximum-current word is at +8. A write changes only the addressed 32-bit word. With one slot configured, the offsets 0x020 to 0x028 are unmapped.
- R6: An aligned access at byte offset 0x100*(i+1) to 0x100*(i+1)+0xFF, for a configured slot i, is passed to slot i's port with the low 8 address bits and the write data. The slot's returned data appears on rsp_rdata with rsp_valid one cycle after the slot's response strobe.
- R7: Bit n of the status word at 0x0FC equals slot_irq[n] as sampled one cycle earlier. Writes to 0x0FC have no effect.
- R8: irq_o is high exactly when at least one configured slot's status bit is set, so one slot releasing its interrupt leaves the output high while another slot still requests.
- R9: An access that is misaligned, hits an unmapped global offset, or hits a window beyond the configured slots is answered one cycle later. The answer has rsp_rdata 0 and rsp_err high for that single cycle. The access changes no register and reaches no slot port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset in the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | 32 | Read data (0 for global writes and errors) |
| rsp_err | output | 1 | Error strobe for unmapped or misaligned access |
| slot_req_valid | output | NUM_SLOTS | Per-slot request strobe |
| slot_req_write | output | 1 | Write flag passed to the slot |
| slot_req_addr | output | 8 | Offset inside the slot sub-window |
| slot_req_wdata | output | 32 | Write data passed to the slot |
| slot_rsp_valid | input | NUM_SLOTS | Per-slot response strobe |
| slot_rsp_rdata | input | 32*NUM_SLOTS | Per-slot response data, slot i in bits 32i+31:32i |
| slot_irq | input | NUM_SLOTS | Per-slot interrupt level |
| irq_o | output | 1 | Combined interrupt |
| soft_rst_o | output | 1 | One-cycle soft-reset pulse to the slots |

## Verification
The bench builds the shell twice with the same request stimulus, once with NUM_SLOTS=2 and once with NUM_SLOTS=1. Every difference that depends on slot count can then be compared side by side: the info reset bits, the second capability block being mapped or unmapped, and the second slot window being forwarded or rejected. Both builds are small enough that every aligned word offset in the 4 KiB window is read after reset, written with an address-derived pattern, and read again. Slot models one cycle deep make the two-cycle slot latency and the routing of the low address bits visible. All four interrupt level patterns are applied.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
  localparam int DW = 32;

  typedef enum logic [3:0] {
    RK_INFO, RK_DEBOUNCE, RK_BUSCFG, RK_WPPOL, RK_CDET, RK_IRQST,
    RK_CAPLO, RK_CAPHI, RK_MAXCUR, RK_SLOT, RK_BAD
  } reg_kind_e;

  // Global page offsets (page 0 of the window)
  localparam logic [7:0] OFS_INFO     = 8'h00;
  localparam logic [7:0] OFS_DEBOUNCE = 8'h04;
  localparam logic [7:0] OFS_BUSCFG   = 8'h08;
  localparam logic [7:0] OFS_WPPOL    = 8'hEC;
  localparam logic [7:0] OFS_CDET     = 8'hF0;
  localparam logic [7:0] OFS_IRQST    = 8'hFC;
  localparam int         CAP_STRIDE   = 16;

  localparam int          INFO_SRST_BIT = 0;
  localparam int          INFO_PRES_LSB = 16;
  localparam logic [31:0] DEBOUNCE_RST  = 32'd5;

  function automatic logic [31:0] info_reset(int n);
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < n; i++) v[INFO_PRES_LSB+i] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/sdw_rst_sync.sv
module sdw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/sdw_decode.sv
module sdw_decode
  import sdw_pkg::*;
#(
  parameter int NUM_SLOTS = 2,
  parameter int AW        = 12,
  parameter int IW        = 1
) (
  input  logic [AW-1:0] addr,
  output reg_kind_e     kind,
  output logic [IW-1:0] idx
);
  localparam int PW = AW - 8;

  logic [PW-1:0] page;
  logic [7:0]    off;
  assign page = addr[AW-1:8];
  assign off  = addr[7:0];

  always_comb begin
    kind = RK_BAD;
    idx  = '0;
    if (addr[1:0] == 2'b00) begin
      if (page == '0) begin
        case (off)
          OFS_INFO:     kind = RK_INFO;
          OFS_DEBOUNCE: kind = RK_DEBOUNCE;
          OFS_BUSCFG:   kind = RK_BUSCFG;
          OFS_WPPOL:    kind = RK_WPPOL;
          OFS_CDET:     kind = RK_CDET;
          OFS_IRQST:    kind = RK_IRQST;
          default:      kind = RK_BAD;
        endcase
        for (int i = 0; i < NUM_SLOTS; i++) begin
          if (off == 8'(CAP_STRIDE*(i+1)))     begin kind = RK_CAPLO;  idx = IW'(i); end
          if (off == 8'(CAP_STRIDE*(i+1) + 4)) begin kind = RK_CAPHI;  idx = IW'(i); end
          if (off == 8'(CAP_STRIDE*(i+1) + 8)) begin kind = RK_MAXCUR; idx = IW'(i); end
        end
      end else begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
          if (page == PW'(i+1)) begin kind = RK_SLOT; idx = IW'(i); end
        end
      end
    end
  end
endmodule

// File: rtl/sdw_irq_collect.sv
module sdw_irq_collect #(
  parameter int NUM_SLOTS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] slot_irq,
  output logic [NUM_SLOTS-1:0] ist_q,
  output logic                 irq_o
);
  logic [NUM_SLOTS-1:0] ist_d;

  always_comb ist_d = slot_irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ist_q <= '0;
    else        ist_q <= ist_d;
  end

  assign irq_o = |ist_q;

  // R8: any requesting slot keeps the combined output up next cycle
  assert_irq_any_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|slot_irq) |=> irq_o);
  // R8: with all levels low the combined output drops next cycle
  assert_irq_none_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|slot_irq) |=> !irq_o);
endmodule

// File: rtl/sdw_glob_regs.sv
module sdw_glob_regs
  import sdw_pkg::*;
#(
  parameter int          NUM_SLOTS = 2,
  parameter int          IW        = 1,
  parameter logic [63:0] CAP_INIT  = 64'h0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  reg_kind_e            kind,
  input  logic [IW-1:0]        idx,
  input  logic [DW-1:0]        wdata,
  input  logic [NUM_SLOTS-1:0] irq_stat,
  output logic [DW-1:0]        rd_word,
  output logic                 soft_rst_o
);
  localparam logic [31:0] INFO_RST = info_reset(NUM_SLOTS);

  logic [DW-1:0] info_q, info_d, deb_q, deb_d, bus_q, bus_d;
  logic [DW-1:0] wpp_q, wpp_d, cdet_q, cdet_d;
  logic          soft_d;
  logic [NUM_SLOTS*64-1:0] cap_flat;
  logic [NUM_SLOTS*32-1:0] maxc_flat;

  always_comb begin
    info_d = info_q; deb_d = deb_q; bus_d = bus_q; wpp_d = wpp_q; cdet_d = cdet_q;
    soft_d = 1'b0;
    if (wr_en) begin
      case (kind)
        RK_INFO: begin
          info_d                = wdata;
          info_d[INFO_SRST_BIT] = 1'b0;
          soft_d                = wdata[INFO_SRST_BIT];
        end
        RK_DEBOUNCE: deb_d  = wdata;
        RK_BUSCFG:   bus_d  = wdata;
        RK_WPPOL:    wpp_d  = wdata;
        RK_CDET:     cdet_d = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      info_q <= INFO_RST; deb_q <= DEBOUNCE_RST; bus_q <= '0;
      wpp_q <= '0; cdet_q <= '0; soft_rst_o <= 1'b0;
    end else begin
      info_q <= info_d; deb_q <= deb_d; bus_q <= bus_d;
      wpp_q <= wpp_d; cdet_q <= cdet_d; soft_rst_o <= soft_d;
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_shadow
    logic [63:0] cap_q, cap_d;
    logic [31:0] maxc_q, maxc_d;
    logic        hit;

    assign hit = wr_en && (idx == IW'(g));

    always_comb begin
      cap_d  = cap_q;
      maxc_d = maxc_q;
      if (hit && kind == RK_CAPLO)  cap_d[31:0]  = wdata;
      if (hit && kind == RK_CAPHI)  cap_d[63:32] = wdata;
      if (hit && kind == RK_MAXCUR) maxc_d       = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cap_q  <= CAP_INIT;
        maxc_q <= '0;
      end else begin
        cap_q  <= cap_d;
        maxc_q <= maxc_d;
      end
    end

    assign cap_flat[g*64 +: 64]  = cap_q;
    assign maxc_flat[g*32 +: 32] = maxc_q;
  end

  always_comb begin
    rd_word = '0;
    case (kind)
      RK_INFO:     rd_word = info_q;
      RK_DEBOUNCE: rd_word = deb_q;
      RK_BUSCFG:   rd_word = bus_q;
      RK_WPPOL:    rd_word = wpp_q;
      RK_CDET:     rd_word = cdet_q;
      RK_IRQST:    rd_word = DW'(irq_stat);
      default: begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
          if (idx == IW'(i)) begin
            if (kind == RK_CAPLO)  rd_word = cap_flat[i*64 +: 32];
            if (kind == RK_CAPHI)  rd_word = cap_flat[i*64+32 +: 32];
            if (kind == RK_MAXCUR) rd_word = maxc_flat[i*32 +: 32];
          end
        end
      end
    endcase
  end

  // R3: the stored info word never holds the request bit
  assert_info_bit0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == RK_INFO) |=> (info_q[INFO_SRST_BIT] == 1'b0));
endmodule

// File: rtl/sdw_wrap.sv
module sdw_wrap
  import sdw_pkg::*;
#(
  parameter int          NUM_SLOTS = 2,
  parameter logic [63:0] CAP_INIT  = 64'h0000_0001_05E8_0032
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [11:0]             req_addr,
  input  logic [31:0]             req_wdata,
  output logic                    rsp_valid,
  output logic [31:0]             rsp_rdata,
  output logic                    rsp_err,
  output logic [NUM_SLOTS-1:0]    slot_req_valid,
  output logic                    slot_req_write,
  output logic [7:0]              slot_req_addr,
  output logic [31:0]             slot_req_wdata,
  input  logic [NUM_SLOTS-1:0]    slot_rsp_valid,
  input  logic [32*NUM_SLOTS-1:0] slot_rsp_rdata,
  input  logic [NUM_SLOTS-1:0]    slot_irq,
  output logic                    irq_o,
  output logic                    soft_rst_o
);
  localparam int IW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic                 rst_s_n;
  reg_kind_e            kind;
  logic [IW-1:0]        idx;
  logic [NUM_SLOTS-1:0] ist;
  logic [DW-1:0]        rd_word;
  logic                 glob_acc, fwd, slot_done;
  logic [DW-1:0]        slot_data;
  logic                 pend_q, pend_d;
  logic [IW-1:0]        pend_idx_q, pend_idx_d;
  logic                 rsp_valid_d, rsp_err_d;
  logic [DW-1:0]        rsp_rdata_d;

  sdw_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n));

  sdw_decode #(.NUM_SLOTS(NUM_SLOTS), .AW(12), .IW(IW)) u_dec (
    .addr(req_addr), .kind(kind), .idx(idx));

  sdw_irq_collect #(.NUM_SLOTS(NUM_SLOTS)) u_irq (
    .clk(clk), .rst_n(rst_s_n), .slot_irq(slot_irq), .ist_q(ist), .irq_o(irq_o));

  assign glob_acc = req_valid && (kind != RK_SLOT);
  assign fwd      = req_valid && (kind == RK_SLOT);

  sdw_glob_regs #(.NUM_SLOTS(NUM_SLOTS), .IW(IW), .CAP_INIT(CAP_INIT)) u_regs (
    .clk(clk), .rst_n(rst_s_n), .wr_en(glob_acc && req_write), .kind(kind),
    .idx(idx), .wdata(req_wdata), .irq_stat(ist), .rd_word(rd_word),
    .soft_rst_o(soft_rst_o));

  // Slot routing
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_route
    assign slot_req_valid[g] = fwd && (idx == IW'(g));
  end
  assign slot_req_write = req_write;
  assign slot_req_addr  = req_addr[7:0];
  assign slot_req_wdata = req_wdata;

  always_comb begin
    slot_done = 1'b0;
    slot_data = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (pend_q && pend_idx_q == IW'(i) && slot_rsp_valid[i]) begin
        slot_done = 1'b1;
        slot_data = slot_rsp_rdata[i*32 +: 32];
      end
    end
  end

  always_comb begin
    pend_d     = pend_q;
    pend_idx_d = pend_idx_q;
    if (slot_done) pend_d = 1'b0;
    if (fwd) begin
      pend_d     = 1'b1;
      pend_idx_d = idx;
    end
  end

  always_comb begin
    rsp_valid_d = glob_acc || slot_done;
    rsp_err_d   = req_valid && (kind == RK_BAD);
    rsp_rdata_d = '0;
    if (slot_done)                                      rsp_rdata_d = slot_data;
    else if (glob_acc && !req_write && kind != RK_BAD)  rsp_rdata_d = rd_word;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      pend_q <= 1'b0; pend_idx_q <= '0;
      rsp_valid <= 1'b0; rsp_err <= 1'b0; rsp_rdata <= '0;
    end else begin
      pend_q <= pend_d; pend_idx_q <= pend_idx_d;
      rsp_valid <= rsp_valid_d; rsp_err <= rsp_err_d; rsp_rdata <= rsp_rdata_d;
    end
  end

  // R6: at most one slot port is addressed at a time
  assert_route_onehot_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0(slot_req_valid));
  // R2: a global access with nothing outstanding is answered next cycle
  assert_glob_latency_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (req_valid && !(|slot_req_valid) && !pend_q) |=> rsp_valid);
  // R9: an error answer carries zero data
  assert_err_zero_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    rsp_err |-> (rsp_valid && rsp_rdata == '0));
  // R9: a misaligned request never reaches a slot port
  assert_misalign_noslot_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (req_valid && req_addr[1:0] != 2'b00) |-> !(|slot_req_valid));
  // R4: a soft-reset pulse is caused by an info write with bit 0 set
  assert_srst_cause_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    soft_rst_o |-> $past(req_valid && req_write && req_addr == 12'h000 && req_wdata[0]));
endmodule

// File: tb/sdw_wrap_tb.sv
module sdw_wrap_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam logic [63:0] TB_CAP     = 64'h0000_0003_1234_A5C1;

  logic clk = 1'b0;
  logic tb_rst_n;
  logic req_valid, req_write;
  logic [11:0] req_addr;
  logic [31:0] req_wdata;
  logic [1:0]  tb_irq;

  logic rv0, re0, irq0, srst0, s0_w;
  logic [31:0] rd0, s0_wd;
  logic [1:0]  s0_v, s0_rv;
  logic [7:0]  s0_a;
  logic [63:0] s0_rd;

  logic rv1, re1, irq1, srst1, s1_w;
  logic [31:0] rd1, s1_wd, s1_rd;
  logic [0:0]  s1_v, s1_rv;
  logic [7:0]  s1_a;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdw_wrap #(.NUM_SLOTS(2), .CAP_INIT(TB_CAP)) dut_i (
    .clk(clk), .rst_n(tb_rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rv0), .rsp_rdata(rd0),
    .rsp_err(re0), .slot_req_valid(s0_v), .slot_req_write(s0_w), .slot_req_addr(s0_a),
    .slot_req_wdata(s0_wd), .slot_rsp_valid(s0_rv), .slot_rsp_rdata(s0_rd),
    .slot_irq(tb_irq), .irq_o(irq0), .soft_rst_o(srst0));

  sdw_wrap #(.NUM_SLOTS(1), .CAP_INIT(TB_CAP)) dut1_i (
    .clk(clk), .rst_n(tb_rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rv1), .rsp_rdata(rd1),
    .rsp_err(re1), .slot_req_valid(s1_v), .slot_req_write(s1_w), .slot_req_addr(s1_a),
    .slot_req_wdata(s1_wd), .slot_rsp_valid(s1_rv), .slot_rsp_rdata(s1_rd),
    .slot_irq(tb_irq[0:0]), .irq_o(irq1), .soft_rst_o(srst1));

  function automatic logic [31:0] spat(int d, int s, int w);
    return 32'h5100_0000 | (32'(d) << 20) | (32'(s) << 16) | 32'(w);
  endfunction

  // Slot register models: one-cycle response
  logic [31:0] ram0 [2][64];
  logic [31:0] ram1 [64];
  always @(posedge clk) begin
    if (!tb_rst_n) begin
      for (int s = 0; s < 2; s++) for (int w = 0; w < 64; w++) ram0[s][w] <= spat(0, s, w);
      for (int w = 0; w < 64; w++) ram1[w] <= spat(1, 0, w);
      s0_rv <= '0; s1_rv <= '0; s0_rd <= '0; s1_rd <= '0;
    end else begin
      s0_rv <= s0_v;
      s1_rv <= s1_v;
      for (int s = 0; s < 2; s++) if (s0_v[s]) begin
        s0_rd[s*32 +: 32] <= ram0[s][s0_a[7:2]];
        if (s0_w) ram0[s][s0_a[7:2]] <= s0_wd;
      end
      if (s1_v[0]) begin
        s1_rd <= ram1[s1_a[7:2]];
        if (s1_w) ram1[s1_a[7:2]] <= s1_wd;
      end
    end
  end

  int fwd_cnt = 0;
  always @(posedge clk) fwd_cnt <= fwd_cnt + $countones(s0_v) + $countones(s1_v);

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Bench expectations
  logic [31:0] gexp [2][64];
  logic [31:0] sexp [2][2][64];

  task automatic init_shadow();
    for (int d = 0; d < 2; d++) begin
      int ns = (d == 0) ? 2 : 1;
      for (int w = 0; w < 64; w++) begin
        gexp[d][w] = '0;
        for (int s = 0; s < 2; s++) sexp[d][s][w] = spat(d, s, w);
      end
      gexp[d][0] = (ns == 2) ? 32'h0003_0000 : 32'h0001_0000;
      gexp[d][1] = 32'd5;
      for (int i = 0; i < ns; i++) begin
        gexp[d][4*(i+1)]     = TB_CAP[31:0];
        gexp[d][4*(i+1) + 1] = TB_CAP[63:32];
      end
    end
  endtask

  function automatic bit glob_ok(int ns, logic [11:0] a);
    logic [7:0] o;
    o = a[7:0];
    if (a[1:0] != 2'b00 || a[11:8] != 4'h0) return 0;
    if (o == 8'h00 || o == 8'h04 || o == 8'h08 || o == 8'hEC || o == 8'hF0 || o == 8'hFC) return 1;
    if (o >= 8'h10 && o < 8'(16*(ns+1)) && (o[3:0] == 4'h0 || o[3:0] == 4'h4 || o[3:0] == 4'h8)) return 1;
    return 0;
  endfunction

  function automatic bit slot_ok(int ns, logic [11:0] a);
    return a[1:0] == 2'b00 && a[11:8] >= 4'd1 && int'(a[11:8]) <= ns;
  endfunction

  function automatic string tag_of(int ns, logic [11:0] a, bit rst);
    if (slot_ok(ns, a))  return "R6";
    if (!glob_ok(ns, a)) return "R9";
    if (rst)             return "R1";
    if (a[7:0] == 8'h00) return "R3";
    if (a[7:0] == 8'hFC) return "R7";
    if (a[7:0] >= 8'h10 && a[7:0] < 8'h30) return "R5";
    return "R2";
  endfunction

  bit          got [2];
  int          lat [2];
  int          ecnt [2];
  logic [31:0] dat [2];
  logic        er [2];

  task automatic acc(logic wr, logic [11:0] a, logic [31:0] d);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    for (int k = 0; k < 2; k++) begin got[k] = 0; ecnt[k] = 0; end
    for (int c = 1; c <= 6; c++) begin
      @(negedge clk);
      if (c == 1) req_valid = 1'b0;
      if (re0) ecnt[0]++;
      if (re1) ecnt[1]++;
      if (!got[0] && rv0) begin got[0] = 1; lat[0] = c; dat[0] = rd0; er[0] = re0; end
      if (!got[1] && rv1) begin got[1] = 1; lat[1] = c; dat[1] = rd1; er[1] = re1; end
    end
  endtask

  // One access to both builds, with expectations and shadow update
  task automatic chk_acc(logic wr, logic [11:0] a, logic [31:0] d, bit rst);
    int f0;
    f0 = fwd_cnt;
    acc(wr, a, d);
    for (int k = 0; k < 2; k++) begin
      int ns = (k == 0) ? 2 : 1;
      string t = tag_of(ns, a, rst);
      bit sl = slot_ok(ns, a);
      bit gl = glob_ok(ns, a);
      logic [31:0] ex = '0;
      if (sl) ex = sexp[k][int'(a[11:8]) - 1][a[7:2]];
      else if (gl && !wr) ex = (a[7:0] == 8'hFC) ? (tb_irq & ((k == 0) ? 2'b11 : 2'b01)) : gexp[k][a[7:2]];
      chk(got[k], t, 32'(got[k]), 32'd1);
      chk(lat[k] == (sl ? 2 : 1), t, 32'(lat[k]), sl ? 32'd2 : 32'd1);
      chk(dat[k] == ex, t, dat[k], ex);
      chk(ecnt[k] == ((sl || gl) ? 0 : 1), t, 32'(ecnt[k]), (sl || gl) ? 32'd0 : 32'd1);
      if (wr && sl) sexp[k][int'(a[11:8]) - 1][a[7:2]] = d;
      if (wr && gl && a[7:0] != 8'hFC) gexp[k][a[7:2]] = (a[7:0] == 8'h00) ? {d[31:1], 1'b0} : d;
    end
    if (!slot_ok(2, a) && !slot_ok(1, a))
      chk(fwd_cnt == f0, "R9", 32'(fwd_cnt - f0), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    tb_rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; tb_irq = 2'b00;
    repeat (4) @(negedge clk);
    tb_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    init_shadow();

    // R1: idle outputs after reset
    chk(!rv0 && !rv1, "R1", {30'd0, rv0, rv1}, 32'd0);
    chk(!irq0 && !irq1, "R1", {30'd0, irq0, irq1}, 32'd0);
    chk(!srst0 && !srst1, "R1", {30'd0, srst0, srst1}, 32'd0);

    // Full read sweep after reset (R1, R6, R9)
    for (int w = 0; w < 1024; w++) chk_acc(1'b0, 12'(w*4), '0, 1'b1);

    // Write sweep then read sweep (R2, R3, R5, R6, R7, R9)
    for (int w = 0; w < 1024; w++) chk_acc(1'b1, 12'(w*4), 32'h9E37_79B9 ^ (32'(w) * 32'h0101_0101), 1'b0);
    for (int w = 0; w < 1024; w++) chk_acc(1'b0, 12'(w*4), '0, 1'b0);

    // R5: one half written, the other unchanged
    chk_acc(1'b1, 12'h010, 32'hDEAD_0001, 1'b0);
    chk_acc(1'b0, 12'h014, '0, 1'b0);
    chk_acc(1'b1, 12'h024, 32'hBEEF_0002, 1'b0);
    chk_acc(1'b0, 12'h020, '0, 1'b0);
    chk_acc(1'b0, 12'h028, '0, 1'b0);

    // R9: misaligned accesses
    chk_acc(1'b0, 12'h001, '0, 1'b0);
    chk_acc(1'b1, 12'h006, 32'hFFFF_FFFF, 1'b0);
    chk_acc(1'b0, 12'h103, '0, 1'b0);
    chk_acc(1'b1, 12'h216, 32'h1234_5678, 1'b0);
    chk_acc(1'b0, 12'h004, '0, 1'b0);

    // R4: soft-reset pulse timing
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h000; req_wdata = 32'h0000_0001;
    @(negedge clk);
    req_valid = 1'b0;
    chk(srst0 && srst1, "R4", {30'd0, srst0, srst1}, 32'd3);
    @(negedge clk);
    chk(!srst0 && !srst1, "R4", {30'd0, srst0, srst1}, 32'd0);
    gexp[0][0] = '0; gexp[1][0] = '0;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h000; req_wdata = 32'h0000_0F00;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!srst0 && !srst1, "R4", {30'd0, srst0, srst1}, 32'd0);
    @(negedge clk);
    gexp[0][0] = 32'h0000_0F00; gexp[1][0] = 32'h0000_0F00;
    chk_acc(1'b0, 12'h000, '0, 1'b0);

    // R7, R8: all interrupt level patterns
    for (int v = 0; v < 4; v++) begin
      tb_irq = 2'(v);
      @(negedge clk);
      chk(irq0 == (v != 0), "R8", {31'd0, irq0}, 32'(v != 0));
      chk(irq1 == v[0], "R8", {31'd0, irq1}, 32'(v[0]));
      chk_acc(1'b1, 12'h0FC, 32'hFFFF_FFFF, 1'b0);
      chk_acc(1'b0, 12'h0FC, '0, 1'b0);
    end
    // R8: slot 0 releasing while slot 1 still requests
    tb_irq = 2'b11; @(negedge clk);
    tb_irq = 2'b10; @(negedge clk);
    chk(irq0, "R8", {31'd0, irq0}, 32'd1);
    chk(!irq1, "R8", {31'd0, irq1}, 32'd0);
    tb_irq = 2'b00; @(negedge clk);
    chk(!irq0, "R8", {31'd0, irq0}, 32'd0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule